// File: doc/BRIEF.md
# Zoned Decimal Address Decoder

This block turns a three-character decimal storage address into a plain binary address between 0 and 15999. Each character is six bits wide: a two-bit zone field in bits [5:4] (bit 5 is the B zone, bit 4 the A zone) and a four-bit numeric code in bits [3:0]. The hundreds, tens and units characters arrive together. The numeric codes give the three decimal digits. The zones on the hundreds and units characters extend the range past 999. The zone on the tens character does not change the address. It is passed out as an index-register selector for the indexing logic further along.

The decode itself is combinational. A parameter `PIPE` places one register stage after it. With the stage present, `in_valid` travels with the data and comes out as `out_valid` one clock later. The registered result is held while `in_valid` is low.

Top module: `zaddr_decoder`

## Requirements
- R1: A numeric code 0 to 9 gives the digit of that value. The code 10 (the 8-2 pattern) gives digit 0. The codes 11 to 15 give the digits 1 to 5.
- R2: The zone field of the hundreds character adds thousands to the address. Zone 2'b01 (A only) adds 1000, 2'b10 (B only) adds 2000, 2'b11 (both) adds 3000, and 2'b00 adds nothing.
- R3: The zone field of the units character adds multiples of 4000. Zone 2'b01 adds 4000, 2'b10 adds 8000, 2'b11 adds 12000, and 2'b00 adds nothing.
- R4: The zone field of the tens character has no effect on `addr_o`. It appears unchanged on `idx_sel_o`, where 2'b00 means no indexing and 2'b01, 2'b10 and 2'b11 select index register A, B and BA.
- R5: `addr_o` equals units digit + 10 × tens digit + 100 × hundreds digit + the two zone contributions, reduced modulo 16000, so it is always below 16000.
- R6: With `PIPE`=1, `out_valid` equals the value `in_valid` had one clock earlier. A result is captured only on a clock where `in_valid` is high. On any other clock, `addr_o` and `idx_sel_o` keep their previous values.
- R7: While `rst_n` is low, `out_valid`, `addr_o` and `idx_sel_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The three input characters are valid on this clock |
| hund_i | input | 6 | Hundreds character: zone in [5:4], numeric code in [3:0] |
| tens_i | input | 6 | Tens character: zone in [5:4], numeric code in [3:0] |
| unit_i | input | 6 | Units character: zone in [5:4], numeric code in [3:0] |
| out_valid | output | 1 | `addr_o` and `idx_sel_o` hold a new result |
| addr_o | output | 14 | Binary address, 0 to 15999 |
| idx_sel_o | output | 2 | Index-register selector taken from the tens zone |

## Verification
A wrong digit table entry shows up as an address that is wrong by exactly one decimal weight. A swapped or wrong zone weight shows up as an error that is a multiple of 1000 or 4000. With the register stage, either error is visible on the clock after the character is presented. The bench therefore sweeps every numeric code in every digit position against every combination of hundreds and units zones. Because each error has its own signature, a failing check points straight at the table or weight involved. A fault in the capture enable shows up on the first idle clock as a changed output or a raised `out_valid`.

// File: rtl/zaddr_pkg.sv
package zaddr_pkg;

  localparam int CHAR_W = 6;
  localparam int NUM_W  = 4;
  localparam int ZONE_W = 2;
  localparam int NDIGIT = 3;

  // Weights contributed by the zone fields of the hundreds and units characters.
  localparam int HUND_ZONE_STEP = 1000;
  localparam int UNIT_ZONE_STEP = 4000;

  typedef struct packed {
    logic [ZONE_W-1:0] zone;  // [1] = B zone, [0] = A zone
    logic [NUM_W-1:0]  num;
  } zchar_t;

  typedef enum logic [ZONE_W-1:0] {
    IDX_NONE = 2'b00,
    IDX_A    = 2'b01,
    IDX_B    = 2'b10,
    IDX_BA   = 2'b11
  } idx_sel_e;

endpackage

// File: rtl/zaddr_digit.sv
// Numeric code to decimal digit (R1).
module zaddr_digit
  import zaddr_pkg::*;
(
  input  logic [NUM_W-1:0] code_i,
  output logic [NUM_W-1:0] val_o
);

  always_comb begin
    unique case (code_i)
      4'd10:                               val_o = '0;            // 8-2 pattern is zero
      4'd11, 4'd12, 4'd13, 4'd14, 4'd15:   val_o = code_i - 4'd10;
      default:                             val_o = code_i;
    endcase
  end

endmodule

// File: rtl/zaddr_sum.sv
// Weighted sum of the digits and zone contributions, reduced into range (R2, R3, R5).
module zaddr_sum
  import zaddr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LIMIT  = 16000
) (
  input  logic [NUM_W-1:0]  hund_val_i,
  input  logic [NUM_W-1:0]  tens_val_i,
  input  logic [NUM_W-1:0]  unit_val_i,
  input  logic [ZONE_W-1:0] hund_zone_i,
  input  logic [ZONE_W-1:0] unit_zone_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] digits;
  logic [SUM_W-1:0] zones;
  logic [SUM_W-1:0] total;

  always_comb begin
    digits = SUM_W'(unit_val_i)
           + SUM_W'(tens_val_i) * SUM_W'(10)
           + SUM_W'(hund_val_i) * SUM_W'(100);
    zones  = SUM_W'(hund_zone_i) * SUM_W'(HUND_ZONE_STEP)
           + SUM_W'(unit_zone_i) * SUM_W'(UNIT_ZONE_STEP);
    total  = digits + zones;
    if (total >= SUM_W'(LIMIT)) begin
      addr_o = ADDR_W'(total - SUM_W'(LIMIT));
    end else begin
      addr_o = ADDR_W'(total);
    end
  end

endmodule

// File: rtl/zaddr_decoder.sv
module zaddr_decoder
  import zaddr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LIMIT  = 16000,
  parameter bit PIPE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] hund_i,
  input  logic [CHAR_W-1:0] tens_i,
  input  logic [CHAR_W-1:0] unit_i,
  output logic              out_valid,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ZONE_W-1:0] idx_sel_o
);

  // Character slots: 0 = units, 1 = tens, 2 = hundreds.
  zchar_t           chr  [NDIGIT];
  logic [NUM_W-1:0] dval [NDIGIT];
  logic [ADDR_W-1:0] addr_c;
  idx_sel_e          idx_c;

  assign chr[0] = zchar_t'(unit_i);
  assign chr[1] = zchar_t'(tens_i);
  assign chr[2] = zchar_t'(hund_i);

  for (genvar g = 0; g < NDIGIT; g++) begin : g_digit
    zaddr_digit u_digit (
      .code_i (chr[g].num),
      .val_o  (dval[g])
    );
  end

  zaddr_sum #(
    .ADDR_W (ADDR_W),
    .LIMIT  (LIMIT)
  ) u_sum (
    .hund_val_i  (dval[2]),
    .tens_val_i  (dval[1]),
    .unit_val_i  (dval[0]),
    .hund_zone_i (chr[2].zone),
    .unit_zone_i (chr[0].zone),
    .addr_o      (addr_c)
  );

  // Tens zone is the index selector only (R4).
  assign idx_c = idx_sel_e'(chr[1].zone);

  if (PIPE) begin : g_reg
    logic              vld_d,  vld_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    idx_sel_e          idx_d,  idx_q;

    always_comb begin
      vld_d  = in_valid;
      addr_d = addr_q;
      idx_d  = idx_q;
      if (in_valid) begin
        addr_d = addr_c;
        idx_d  = idx_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        idx_q  <= IDX_NONE;
      end else begin
        vld_q  <= vld_d;
        addr_q <= addr_d;
        idx_q  <= idx_d;
      end
    end

    assign out_valid = vld_q;
    assign addr_o    = addr_q;
    assign idx_sel_o = idx_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign addr_o    = addr_c;
    assign idx_sel_o = idx_c;
  end

endmodule

// File: rtl/zaddr_decoder_chk.sv
module zaddr_decoder_chk
  import zaddr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LIMIT  = 16000,
  parameter bit PIPE   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CHAR_W-1:0] hund_i,
  input logic [CHAR_W-1:0] tens_i,
  input logic [CHAR_W-1:0] unit_i,
  input logic              out_valid,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ZONE_W-1:0] idx_sel_o
);

  if (PIPE) begin : g_seq
    always @(posedge clk) begin
      if (!rst_n) begin
        a_r7_reset_zero: assert (!out_valid && addr_o == '0 && idx_sel_o == '0)
          else $error("R7 outputs not cleared in reset");
      end
    end

    a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    a_r6_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(addr_o) && $stable(idx_sel_o)));

    a_r4_idx_from_tens: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (idx_sel_o == $past(tens_i[5:4])));

    a_r2_no_zone_small: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hund_i[5:4] == 2'b00 && unit_i[5:4] == 2'b00)
        |=> (addr_o < ADDR_W'(1000)));

    a_r3_unit_zone_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && unit_i[5:4] == 2'b11) |=> (addr_o >= ADDR_W'(12000)));

    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (addr_o < ADDR_W'(LIMIT)));
  end else begin : g_comb
    always @(posedge clk) begin
      if (rst_n && in_valid) begin
        a_r5_in_range: assert (addr_o < ADDR_W'(LIMIT))
          else $error("R5 address out of range");
        a_r4_idx_from_tens: assert (idx_sel_o == tens_i[5:4])
          else $error("R4 index selector mismatch");
      end
    end
  end

endmodule

bind zaddr_decoder zaddr_decoder_chk #(
  .ADDR_W (ADDR_W),
  .LIMIT  (LIMIT),
  .PIPE   (PIPE)
) u_zaddr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .hund_i    (hund_i),
  .tens_i    (tens_i),
  .unit_i    (unit_i),
  .out_valid (out_valid),
  .addr_o    (addr_o),
  .idx_sel_o (idx_sel_o)
);

// File: tb/test_zaddr_decoder.sv
`timescale 1ns/1ps
module test_zaddr_decoder;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  hund_i, tens_i, unit_i;
  logic        out_valid;
  logic [13:0] addr_o;
  logic [1:0]  idx_sel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  zaddr_decoder i_zaddr_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .hund_i    (hund_i),
    .tens_i    (tens_i),
    .unit_i    (unit_i),
    .out_valid (out_valid),
    .addr_o    (addr_o),
    .idx_sel_o (idx_sel_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected digit value of a numeric code (R1).
  function automatic int digit_of(input int code);
    if (code == 10)     return 0;
    else if (code > 10) return code - 10;
    else                return code;
  endfunction

  // Expected address (R2, R3, R5).
  function automatic int exp_addr(input logic [5:0] h, input logic [5:0] t, input logic [5:0] u);
    int s;
    s = digit_of(int'(u[3:0])) + 10 * digit_of(int'(t[3:0])) + 100 * digit_of(int'(h[3:0]))
      + 1000 * int'(h[5:4]) + 4000 * int'(u[5:4]);
    return s % 16000;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present one set of characters, then sample after the capturing edge.
  task automatic apply(input string tag, input logic [5:0] h, input logic [5:0] t, input logic [5:0] u);
    @(negedge clk);
    hund_i = h; tens_i = t; unit_i = u; in_valid = 1'b1;
    @(negedge clk);
    check({tag, " valid"}, int'(out_valid), 1);
    check(tag, int'(addr_o), exp_addr(h, t, u));
    check({tag, " idx"}, int'(idx_sel_o), int'(t[5:4]));
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1401));
    rst_n = 1'b0; in_valid = 1'b0;
    hund_i = '0; tens_i = '0; unit_i = '0;
    repeat (3) @(negedge clk);
    // R7: outputs clear in reset
    check("R7 valid", int'(out_valid), 0);
    check("R7 addr", int'(addr_o), 0);
    check("R7 idx", int'(idx_sel_o), 0);
    rst_n = 1'b1;

    // R1: every numeric code in every digit position
    for (int n = 0; n < 16; n++) begin
      apply("R1 units", 6'h00, 6'h00, 6'(n));
      apply("R1 tens", 6'h00, 6'(n), 6'h00);
      apply("R1 hund", 6'(n), 6'h00, 6'h00);
    end

    // R2 and R3: every hundreds/units zone pair with a digit sweep
    for (int hz = 0; hz < 4; hz++) begin
      for (int uz = 0; uz < 4; uz++) begin
        for (int n = 0; n < 16; n++) begin
          apply(uz == 0 ? "R2 zone" : "R3 zone",
                {2'(hz), 4'(n)}, {2'b00, 4'((n + 5) % 16)}, {2'(uz), 4'(15 - n)});
        end
      end
    end

    // R4: tens zone changes only the selector
    for (int tz = 0; tz < 4; tz++) begin
      apply("R4 tens zone", 6'h07, {2'(tz), 4'd3}, 6'h14);
      check("R4 addr unaffected", int'(addr_o), 1000 * 0 + 700 + 30 + 4000 + 4);
    end

    // R5: top of range and 8-2 corners
    apply("R5 max", 6'h39, 6'h09, 6'h39);
    check("R5 max value", int'(addr_o), 15999);
    apply("R5 eight-two", 6'h3A, 6'h0A, 6'h3A);
    check("R5 eight-two value", int'(addr_o), 15000);
    apply("R5 high codes", 6'h3F, 6'h3F, 6'h3F);

    // R6: idle clocks hold the result and drop valid
    apply("R6 load", 6'h25, 6'h16, 6'h27);
    @(negedge clk);
    hund_i = 6'h01; tens_i = 6'h02; unit_i = 6'h03; in_valid = 1'b0;
    @(negedge clk);
    check("R6 idle valid", int'(out_valid), 0);
    check("R6 idle addr", int'(addr_o), exp_addr(6'h25, 6'h16, 6'h27));
    check("R6 idle idx", int'(idx_sel_o), 1);
    @(negedge clk);
    check("R6 idle addr 2", int'(addr_o), exp_addr(6'h25, 6'h16, 6'h27));

    // R5: constrained random
    for (int k = 0; k < 1500; k++) begin
      apply("R5 random", 6'($urandom), 6'($urandom), 6'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule